// File: doc/BRIEF.md
# Fuse Controller Register Front End

This block is the register file that software sees when it drives a one-time-programmable fuse controller. It decodes a small 32-bit register bus. The registers are a control word, two aliases of that control word (one ORs written bits in, the other clears them), a free timing word that is passed out to the burn sequencer, and a set of data words. A program access has three steps. Software writes a 16-bit unlock key into the control word, together with the target address. It then writes the payload. Finally, a write to the first data word hands the request to an external programming sequencer through a request/done handshake.

The target address is copied when the request is accepted, and the key is consumed by that acceptance. Each word can be protected by an external lock input. A request that targets a protected word never reaches the sequencer. Instead it raises a sticky error flag, and that flag blocks every later program or reload request until software clears it through the clear alias. A reload request for the shadow copies is passed out through a second request/done handshake.

The `BANKED` parameter selects the layout. When it is set, there are four data words and the address selects a bank of four fuse words. When it is clear, there is one data word and the address selects a single fuse word. Bus reads return data one cycle after the request, marked by a valid strobe.

Top module: `fuse_ctl_regs`

## Requirements
- R1: After reset, the control word, timing word and every data word read as zero, and `prog_req` and `reload_req` are low.
- R2: A read at byte offset 0x00, 0x04 or 0x08 returns the control word. A read at 0x10 returns the timing word. A read at 0x20 + 0x10*i returns data word i. Any other offset returns zero. `bus_rdata` and `bus_rvalid` are valid in the cycle after `bus_rd`. The timing word also drives `timing_cfg`.
- R3: The control word has these fields: the address in bits ADDR_W-1:0, busy in bit 8, error in bit 9, reload in bit 10 and the key in bits 31:16. Address and key are writable. A write at 0x04 ORs bits into them and a write at 0x08 clears bits in them. Busy and error cannot be set by any control write.
- R4: A write to data word 0 while the key field holds 0x3E77, with busy, error and reload all clear and the target unlocked, starts a program request. In the next cycle `prog_req` is high, busy reads 1 and the key field reads 0.
- R5: `prog_addr` holds the address captured at acceptance until completion, even if the address field is rewritten in the meantime.
- R6: While busy, writes to any data word are ignored, and both the read-back value and `prog_data` stay unchanged.
- R7: A `prog_done` pulse while busy clears `prog_req` and busy in the next cycle.
- R8: The key is used once per access. A second write to data word 0 after completion, without a fresh key, starts nothing.
- R9: A write to a data word without the armed key only stores the data. `prog_req` stays low.
- R10: If any lock bit covering the target is high (lock index = address*words-per-bank + word), an armed write to data word 0 raises no request and sets no busy. It sets error and clears the key.
- R11: While error is set, an armed write to data word 0 and a reload request are both ignored, and the key is kept. Error is cleared only by writing 1 to bit 9 at offset 0x08. A write at 0x00 does not clear it.
- R12: In banked mode, armed writes to data words 1 to 3 start nothing and keep the key. `prog_data` carries word i in bits 32*i+31:32*i.
- R13: Writing 1 to bit 10 at 0x00 or 0x04 while idle raises `reload_req` and the reload bit until `reload_done`. The request is ignored while busy, and no program request starts while a reload is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| lock_mask | input | (2**ADDR_W)*NDATA | Per-fuse-word program lock |
| timing_cfg | output | 32 | Timing word for the burn sequencer |
| prog_req | output | 1 | Program request to the sequencer (equals busy) |
| prog_addr | output | ADDR_W | Address captured at acceptance |
| prog_data | output | NDATA*32 | Data words for the burn |
| prog_done | input | 1 | Sequencer completion pulse |
| reload_req | output | 1 | Shadow reload request |
| reload_done | input | 1 | Reload completion pulse |

## Verification
The program path is tried with several sequences:
- A data write with no key, which checks that storing data and arming are kept apart.
- Armed writes to the upper data words followed by data word 0, which checks that only word 0 triggers.
- Address and data rewrites during busy, which check the snapshot and the write freeze.
- A repeat write after completion, which checks that the key is consumed.
- An armed write into a bank whose third word alone is locked, which checks that the lock covers the whole bank.

The error and reload flags are then exercised against armed writes, main-offset writes and clear-alias writes. This shows that only the clear alias releases the sticky error, and that a pending reload blocks programming without consuming the key.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;
  localparam int KEY_W   = 16;
  localparam int KEY_LSB = 16;
  localparam int BIT_BUSY   = 8;
  localparam int BIT_ERR    = 9;
  localparam int BIT_RELOAD = 10;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77;

  localparam logic [7:0] OFS_CTRL    = 8'h00;
  localparam logic [7:0] OFS_SET     = 8'h04;
  localparam logic [7:0] OFS_CLR     = 8'h08;
  localparam logic [7:0] OFS_TIMING  = 8'h10;
  localparam logic [7:0] OFS_DATA0   = 8'h20;
  localparam logic [7:0] DATA_STRIDE = 8'h10;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2
  } ctl_op_e;
endpackage

// File: rtl/fuse_ctrl_reg.sv
module fuse_ctrl_reg
  import fuse_ctl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  ctl_op_e           op,
  input  logic [ADDR_W-1:0] addr_w,
  input  logic [KEY_W-1:0]  key_w,
  input  logic              err_w,
  input  logic              reload_w,
  input  logic              busy,
  input  logic              start,
  input  logic              reject,
  input  logic              reload_done,
  output logic [ADDR_W-1:0] addr_q,
  output logic [KEY_W-1:0]  key_q,
  output logic              err_q,
  output logic              reload_q,
  output logic              armed
);
  logic [ADDR_W-1:0] addr_nx;
  logic [KEY_W-1:0]  key_nx;
  logic              reload_set;

  always_comb begin
    unique case (op)
      OP_SET: begin
        addr_nx = addr_q | addr_w;
        key_nx  = key_q | key_w;
      end
      OP_CLR: begin
        addr_nx = addr_q & ~addr_w;
        key_nx  = key_q & ~key_w;
      end
      default: begin
        addr_nx = addr_w;
        key_nx  = key_w;
      end
    endcase
  end

  assign reload_set = wr_en && (op != OP_CLR) && reload_w &&
                      !busy && !err_q && !reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      key_q    <= '0;
      err_q    <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      if (wr_en) begin
        addr_q <= addr_nx;
        key_q  <= key_nx;
      end else if (start || reject) begin
        key_q <= '0;
      end
      if (reject)
        err_q <= 1'b1;
      else if (wr_en && (op == OP_CLR) && err_w)
        err_q <= 1'b0;
      if (reload_q && reload_done)
        reload_q <= 1'b0;
      else if (reload_set)
        reload_q <= 1'b1;
    end
  end

  assign armed = (key_q == UNLOCK_KEY);
endmodule

// File: rtl/fuse_data_bank.sv
module fuse_data_bank #(
  parameter int NDATA  = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NDATA-1:0]        we,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    hold,
  output logic [NDATA*DATA_W-1:0] data_flat
);
  for (genvar i = 0; i < NDATA; i++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)
        word_q <= '0;
      else if (we[i] && !hold)
        word_q <= wdata;
    end
    assign data_flat[i*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/fuse_prog_issue.sv
module fuse_prog_issue #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data0_we,
  input  logic              armed,
  input  logic              err,
  input  logic              reload_active,
  input  logic              lock_hit,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              done,
  output logic              start,
  output logic              reject,
  output logic              busy_q,
  output logic [ADDR_W-1:0] addr_snap
);
  logic go;

  assign go     = data0_we && armed && !busy_q && !err && !reload_active;
  assign start  = go && !lock_hit;
  assign reject = go && lock_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      addr_snap <= '0;
    end else if (start) begin
      busy_q    <= 1'b1;
      addr_snap <= addr_in;
    end else if (busy_q && done) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fuse_ctl_regs.sv
module fuse_ctl_regs
  import fuse_ctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter bit BANKED = 1'b1,
  localparam int NDATA  = BANKED ? 4 : 1,
  localparam int NLOCK  = (1 << ADDR_W) * NDATA
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NLOCK-1:0]     lock_mask,
  output logic [31:0]          timing_cfg,
  output logic                 prog_req,
  output logic [ADDR_W-1:0]    prog_addr,
  output logic [NDATA*32-1:0]  prog_data,
  input  logic                 prog_done,
  output logic                 reload_req,
  input  logic                 reload_done
);
  localparam int IDX_W = $clog2(NLOCK);

  logic              ctl_wr;
  ctl_op_e           ctl_op;
  logic [NDATA-1:0]  data_we;
  logic [ADDR_W-1:0] addr_q;
  logic [KEY_W-1:0]  key_q;
  logic              err_q, reload_q, armed;
  logic              start, reject, busy_q;
  logic [NDATA-1:0]  lock_bits;
  logic              lock_hit;
  logic [31:0]       timing_q;
  logic [31:0]       ctl_word;
  logic [31:0]       rmux;

  always_comb begin
    ctl_wr = bus_wr;
    ctl_op = OP_PLAIN;
    unique case (bus_addr)
      OFS_CTRL: ctl_op = OP_PLAIN;
      OFS_SET:  ctl_op = OP_SET;
      OFS_CLR:  ctl_op = OP_CLR;
      default:  ctl_wr = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NDATA; i++) begin : g_dec
    assign data_we[i] = bus_wr && (bus_addr == OFS_DATA0 + 8'(i) * DATA_STRIDE);
  end

  for (genvar w = 0; w < NDATA; w++) begin : g_lock
    logic [IDX_W-1:0] idx;
    assign idx          = IDX_W'(addr_q) * IDX_W'(NDATA) + IDX_W'(w);
    assign lock_bits[w] = lock_mask[idx];
  end
  assign lock_hit = |lock_bits;

  fuse_ctrl_reg #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (ctl_wr),
    .op          (ctl_op),
    .addr_w      (bus_wdata[ADDR_W-1:0]),
    .key_w       (bus_wdata[KEY_LSB +: KEY_W]),
    .err_w       (bus_wdata[BIT_ERR]),
    .reload_w    (bus_wdata[BIT_RELOAD]),
    .busy        (busy_q),
    .start       (start),
    .reject      (reject),
    .reload_done (reload_done),
    .addr_q      (addr_q),
    .key_q       (key_q),
    .err_q       (err_q),
    .reload_q    (reload_q),
    .armed       (armed)
  );

  fuse_prog_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk           (clk),
    .rst           (rst),
    .data0_we      (data_we[0]),
    .armed         (armed),
    .err           (err_q),
    .reload_active (reload_q),
    .lock_hit      (lock_hit),
    .addr_in       (addr_q),
    .done          (prog_done),
    .start         (start),
    .reject        (reject),
    .busy_q        (busy_q),
    .addr_snap     (prog_addr)
  );

  fuse_data_bank #(.NDATA(NDATA), .DATA_W(32)) u_data (
    .clk       (clk),
    .rst       (rst),
    .we        (data_we),
    .wdata     (bus_wdata),
    .hold      (busy_q),
    .data_flat (prog_data)
  );

  always_ff @(posedge clk) begin
    if (rst)
      timing_q <= '0;
    else if (bus_wr && bus_addr == OFS_TIMING)
      timing_q <= bus_wdata;
  end
  assign timing_cfg = timing_q;

  always_comb begin
    ctl_word = '0;
    ctl_word[7:0]                 = 8'(addr_q);
    ctl_word[BIT_BUSY]            = busy_q;
    ctl_word[BIT_ERR]             = err_q;
    ctl_word[BIT_RELOAD]          = reload_q;
    ctl_word[KEY_LSB +: KEY_W]    = key_q;
  end

  always_comb begin
    rmux = '0;
    if (bus_addr == OFS_CTRL || bus_addr == OFS_SET || bus_addr == OFS_CLR)
      rmux = ctl_word;
    else if (bus_addr == OFS_TIMING)
      rmux = timing_q;
    else
      for (int i = 0; i < NDATA; i++)
        if (bus_addr == OFS_DATA0 + 8'(i) * DATA_STRIDE)
          rmux = prog_data[i*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd)
        bus_rdata <= rmux;
    end
  end

  assign prog_req   = busy_q;
  assign reload_req = reload_q;
endmodule

// File: rtl/fuse_ctl_regs_chk.sv
module fuse_ctl_regs_chk #(
  parameter int ADDR_W = 6,
  parameter int DW     = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              prog_req,
  input logic              prog_done,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [DW-1:0]     prog_data,
  input logic              reload_req,
  input logic              err_q,
  input logic [15:0]       key_q
);
  assert_key_consumed_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_req) |-> key_q == '0);

  assert_addr_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    prog_req && $past(prog_req) |-> $stable(prog_addr));

  assert_data_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    prog_req && $past(prog_req) |-> $stable(prog_data));

  assert_done_releases_R7: assert property (@(posedge clk) disable iff (rst)
    prog_req && prog_done |=> !prog_req);

  assert_error_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_req) |-> !$past(err_q));

  assert_no_overlap_R13: assert property (@(posedge clk) disable iff (rst)
    !(reload_req && prog_req));
endmodule

bind fuse_ctl_regs fuse_ctl_regs_chk #(.ADDR_W(ADDR_W), .DW(NDATA*32)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .prog_req   (prog_req),
  .prog_done  (prog_done),
  .prog_addr  (prog_addr),
  .prog_data  (prog_data),
  .reload_req (reload_req),
  .err_q      (err_q),
  .key_q      (key_q)
);

// File: tb/sim_fuse_ctl_regs.sv
module sim_fuse_ctl_regs;
  localparam int ADDR_W = 6;
  localparam int NDATA  = 4;
  localparam int NLOCK  = (1 << ADDR_W) * NDATA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [NLOCK-1:0] lock_mask = '0;
  logic [31:0] timing_cfg;
  logic        prog_req;
  logic [ADDR_W-1:0] prog_addr;
  logic [NDATA*32-1:0] prog_data;
  logic prog_done = 1'b0, reload_req, reload_done = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  fuse_ctl_regs #(.ADDR_W(ADDR_W), .BANKED(1'b1)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .lock_mask(lock_mask), .timing_cfg(timing_cfg), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .prog_done(prog_done),
    .reload_req(reload_req), .reload_done(reload_done));

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        chk(bus_rdata, 128'hx, "R2 unexpected read data");
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata, e, t);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_prog_done();
    @(negedge clk); prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;
  endtask

  task automatic pulse_reload_done();
    @(negedge clk); reload_done = 1'b1;
    @(negedge clk); reload_done = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    lock_mask[9*4+2] = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(prog_req, 0, "R1 prog_req");
    chk(reload_req, 0, "R1 reload_req");
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h10, 32'h0, "R1 timing");
    rd(8'h20, 32'h0, "R1 data0");
    // R2 decode
    wr(8'h10, 32'h0012_3456);
    chk(timing_cfg, 32'h0012_3456, "R2 timing_cfg");
    rd(8'h10, 32'h0012_3456, "R2 timing read");
    rd(8'h60, 32'h0, "R2 unmapped");
    // R3 fields and aliases
    wr(8'h00, 32'h0000_00FF);
    rd(8'h00, 32'h0000_003F, "R3 addr width");
    wr(8'h00, 32'h0000_0010);
    wr(8'h04, 32'h0000_0003);
    rd(8'h04, 32'h0000_0013, "R3 set alias");
    wr(8'h08, 32'h0000_0001);
    rd(8'h08, 32'h0000_0012, "R3 clr alias");
    wr(8'h00, 32'h0000_0312);
    rd(8'h00, 32'h0000_0012, "R3 status read-only");
    // R9 plain data write
    wr(8'h20, 32'hDEAD_0001);
    chk(prog_req, 0, "R9 no start");
    rd(8'h20, 32'hDEAD_0001, "R9 data stored");
    // R12 armed upper words do not trigger
    wr(8'h00, 32'h3E77_0012);
    wr(8'h30, 32'h0000_0011);
    chk(prog_req, 0, "R12 data1 no trigger");
    wr(8'h40, 32'h0000_0022);
    wr(8'h50, 32'h0000_0033);
    rd(8'h00, 32'h3E77_0012, "R12 key kept");
    // R4 start
    wr(8'h20, 32'h0000_00A0);
    chk(prog_req, 1, "R4 prog_req");
    chk(prog_addr, 6'h12, "R4 prog_addr");
    chk(prog_data, {32'h33, 32'h22, 32'h11, 32'hA0}, "R12 prog_data layout");
    rd(8'h00, 32'h0000_0112, "R4 busy and key cleared");
    // R5/R6 during busy
    wr(8'h00, 32'h0000_0007);
    chk(prog_addr, 6'h12, "R5 snapshot held");
    rd(8'h00, 32'h0000_0107, "R5 addr field rewritten");
    wr(8'h20, 32'h0000_FFFF);
    wr(8'h40, 32'h0000_FFFF);
    rd(8'h20, 32'h0000_00A0, "R6 data0 frozen");
    rd(8'h40, 32'h0000_0022, "R6 data2 frozen");
    chk(prog_data, {32'h33, 32'h22, 32'h11, 32'hA0}, "R6 prog_data frozen");
    wr(8'h04, 32'h0000_0400);
    chk(reload_req, 0, "R13 reload ignored while busy");
    // R7 completion
    pulse_prog_done();
    chk(prog_req, 0, "R7 prog_req cleared");
    rd(8'h00, 32'h0000_0007, "R7 busy cleared");
    // R8 key consumed
    wr(8'h20, 32'h0000_0005);
    chk(prog_req, 0, "R8 no restart without key");
    // R10 locked bank
    wr(8'h00, 32'h3E77_0009);
    wr(8'h20, 32'h0000_0001);
    chk(prog_req, 0, "R10 no request");
    rd(8'h00, 32'h0000_0209, "R10 error set key cleared");
    // R11 error blocks
    wr(8'h00, 32'h3E77_0003);
    wr(8'h20, 32'h0000_0002);
    chk(prog_req, 0, "R11 blocked by error");
    wr(8'h04, 32'h0000_0400);
    chk(reload_req, 0, "R11 reload blocked");
    wr(8'h00, 32'h3E77_0003);
    rd(8'h00, 32'h3E77_0203, "R11 main write keeps error");
    wr(8'h08, 32'h0000_0200);
    rd(8'h00, 32'h3E77_0003, "R11 clr alias releases");
    wr(8'h20, 32'h0000_0002);
    chk(prog_req, 1, "R11 start after clear");
    chk(prog_addr, 6'h03, "R11 addr after clear");
    pulse_prog_done();
    // R13 reload
    wr(8'h04, 32'h0000_0400);
    chk(reload_req, 1, "R13 reload_req");
    rd(8'h00, 32'h0000_0403, "R13 reload bit");
    wr(8'h00, 32'h3E77_0003);
    wr(8'h20, 32'h0000_0004);
    chk(prog_req, 0, "R13 program blocked by reload");
    pulse_reload_done();
    chk(reload_req, 0, "R13 reload done");
    rd(8'h00, 32'h3E77_0003, "R13 key kept after block");
    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "R2 all reads returned");
    summary();
  end
endmodule